// File: doc/BRIEF.md
# Universal PLA Test Sequence Generator

This block steps a self-testing PLA through its function-independent test order. It drives two force lines and the input register that feeds the input decoder. It also drives an active-low product-line select vector, so that every product line except the selected one can be disabled. Asserting `force_true_o` drives every true-side bit line to zero. Asserting `force_comp_o` drives every complement-side bit line to zero.

A start request launches one pass made of five pattern classes. The first is a single all-quiet pattern. Two classes walk one enabled product line across the array with all bit lines held low. Two more classes visit every product line for each single bit line, first on the true side and then on the complement side.

A compare strobe tells the downstream cumulative-parity checker which cycles to examine. The strobe is set on every cycle of the first three classes and only once per bit line in the last two. Because the order is fixed, the expected parity sequence stays trivially regular. A 3-bit phase code is exported for debug, and a one-cycle done pulse marks the end of the pass.

Top module: `pla_tseq_gen`

## Requirements
- R1: After reset and while idle, the outputs are as follows: phase is 0, `force_true_o` and `force_comp_o` are 1, `in_vec_o` is all zeros, `prod_sel_no` is all ones, and `cmp_stb_o` and `done_o` are 0.
- R2: The cycle after `start_i` is sampled high while idle carries the quiet pattern. That pattern is: phase 1, both force lines 1, `in_vec_o` all zeros, `prod_sel_no` all ones, and `cmp_stb_o` 1. It lasts exactly one cycle.
- R3: Next come N_PROD cycles of phase 2, with j running 0 to N_PROD-1. In each one, `prod_sel_no` has bit j at 0 and all other bits at 1, `in_vec_o` is all ones, both force lines are 1, and `cmp_stb_o` is 1.
- R4: Next come N_PROD cycles of phase 3, identical to phase 2 except that `in_vec_o` is all zeros.
- R5: Phase 4 follows, with i running 0 to N_IN-1 as the outer loop and j running 0 to N_PROD-1 as the inner loop. In each cycle, `force_true_o` is 0, `force_comp_o` is 1, `in_vec_o` has only bit i set, and `prod_sel_no` has only bit j at 0.
- R6: Phase 5 follows with the same nesting. In each cycle, `force_true_o` is 1, `force_comp_o` is 0, `in_vec_o` is all ones except bit i, and `prod_sel_no` has only bit j at 0.
- R7: In phases 4 and 5, `cmp_stb_o` is 1 only on the cycle where j = N_PROD-1.
- R8: A pass lasts exactly 1 + 2·N_PROD + 2·N_IN·N_PROD cycles. On the next cycle the block is idle and `done_o` is 1, for exactly one cycle.
- R9: `start_i` has no effect while a pass is running.
- R10: A start sampled in the cycle where `done_o` is high is accepted, and the next cycle begins a new pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, honoured only while idle |
| force_true_o | output | 1 | Forces all true-side bit lines to zero |
| force_comp_o | output | 1 | Forces all complement-side bit lines to zero |
| in_vec_o | output | N_IN | Input register contents |
| prod_sel_no | output | N_PROD | Product-line enables, active low |
| phase_o | output | 3 | Phase code: 0 idle, 1 to 5 for the pattern classes |
| cmp_stb_o | output | 1 | Compare strobe for the parity checker |
| done_o | output | 1 | One-cycle pulse after the final pattern |

## Verification
The end of a pass and the start of a new one can fall in the same cycle. This happens when `start_i` is high while `done_o` is being pulsed. The bench holds `start_i` high for an entire pass, which also exercises R9. It then expects, cycle by cycle, the done cycle immediately followed by a fresh quiet pattern and a complete second sequence. Every cycle of each pass is compared with patterns computed from the loop indices in the bench.

// File: rtl/pla_tseq_pkg.sv
package pla_tseq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_QUIET   = 3'd1,
    PH_PROD_HI = 3'd2,
    PH_PROD_LO = 3'd3,
    PH_BIT_T   = 3'd4,
    PH_BIT_C   = 3'd5
  } phase_e;
endpackage

// File: rtl/pla_tseq_ring.sv
// One-hot position register; rotates by one per step, wraps after the top bit.
module pla_tseq_ring #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  output logic [W-1:0] pos_o,
  output logic         last_o
);
  localparam logic [W-1:0] FIRST = W'(1);

  logic [W-1:0] pos_q, pos_next;

  generate
    if (W == 1) begin : g_single
      assign pos_next = pos_q;
    end else begin : g_rot
      assign pos_next = {pos_q[W-2:0], pos_q[W-1]};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= FIRST;
    else if (clr_i)  pos_q <= FIRST;
    else if (step_i) pos_q <= pos_next;
  end

  assign pos_o  = pos_q;
  assign last_o = pos_q[W-1];

  a_r3_ring_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(pos_q));
endmodule

// File: rtl/pla_tseq_ctrl.sv
module pla_tseq_ctrl
  import pla_tseq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   prod_last_i,
  input  logic   bit_last_i,
  output phase_e phase_o,
  output logic   ring_clr_o,
  output logic   prod_step_o,
  output logic   bit_step_o,
  output logic   done_o
);
  phase_e phase_q, phase_d;
  logic   done_q;
  logic   in_bits;

  assign in_bits = (phase_q == PH_BIT_T) || (phase_q == PH_BIT_C);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:    if (start_i) phase_d = PH_QUIET;
      PH_QUIET:   phase_d = PH_PROD_HI;
      PH_PROD_HI: if (prod_last_i) phase_d = PH_PROD_LO;
      PH_PROD_LO: if (prod_last_i) phase_d = PH_BIT_T;
      PH_BIT_T:   if (prod_last_i && bit_last_i) phase_d = PH_BIT_C;
      PH_BIT_C:   if (prod_last_i && bit_last_i) phase_d = PH_IDLE;
      default:    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= (phase_q == PH_BIT_C) && prod_last_i && bit_last_i;
    end
  end

  assign ring_clr_o  = (phase_q == PH_IDLE) || (phase_q == PH_QUIET);
  assign prod_step_o = (phase_q == PH_PROD_HI) || (phase_q == PH_PROD_LO) || in_bits;
  assign bit_step_o  = in_bits && prod_last_i;
  assign phase_o     = phase_q;
  assign done_o      = done_q;

  a_r2_quiet_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_QUIET) |=> (phase_q == PH_PROD_HI));
  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_BIT_T) |=> (phase_q == PH_BIT_T || phase_q == PH_BIT_C));
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r8_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (phase_q == PH_IDLE) && ($past(phase_q) == PH_BIT_C));
endmodule

// File: rtl/pla_tseq_decode.sv
module pla_tseq_decode
  import pla_tseq_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_PROD = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic [N_PROD-1:0] prod_pos_i,
  input  logic [N_IN-1:0]   bit_pos_i,
  input  logic              prod_last_i,
  output logic              force_true_o,
  output logic              force_comp_o,
  output logic [N_IN-1:0]   in_vec_o,
  output logic [N_PROD-1:0] prod_sel_no,
  output logic              cmp_stb_o
);
  always_comb begin
    force_true_o = 1'b1;
    force_comp_o = 1'b1;
    in_vec_o     = '0;
    prod_sel_no  = '1;
    cmp_stb_o    = 1'b0;
    unique case (phase_i)
      PH_QUIET: cmp_stb_o = 1'b1;
      PH_PROD_HI: begin
        in_vec_o    = '1;
        prod_sel_no = ~prod_pos_i;
        cmp_stb_o   = 1'b1;
      end
      PH_PROD_LO: begin
        prod_sel_no = ~prod_pos_i;
        cmp_stb_o   = 1'b1;
      end
      PH_BIT_T: begin
        force_true_o = 1'b0;
        in_vec_o     = bit_pos_i;
        prod_sel_no  = ~prod_pos_i;
        cmp_stb_o    = prod_last_i;
      end
      PH_BIT_C: begin
        force_comp_o = 1'b0;
        in_vec_o     = ~bit_pos_i;
        prod_sel_no  = ~prod_pos_i;
        cmp_stb_o    = prod_last_i;
      end
      default: ;
    endcase
  end

  a_r7_strobe_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_i == PH_BIT_T || phase_i == PH_BIT_C) && cmp_stb_o) |-> !prod_sel_no[N_PROD-1]);
  a_r5_single_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(force_true_o == 1'b0 && force_comp_o == 1'b0));
  a_r3_one_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != PH_IDLE && phase_i != PH_QUIET) |-> ($countones(~prod_sel_no) == 1));
endmodule

// File: rtl/pla_tseq_gen.sv
module pla_tseq_gen
  import pla_tseq_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_PROD = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              force_true_o,
  output logic              force_comp_o,
  output logic [N_IN-1:0]   in_vec_o,
  output logic [N_PROD-1:0] prod_sel_no,
  output logic [2:0]        phase_o,
  output logic              cmp_stb_o,
  output logic              done_o
);
  phase_e            phase;
  logic              ring_clr, prod_step, bit_step;
  logic              prod_last, bit_last;
  logic [N_PROD-1:0] prod_pos;
  logic [N_IN-1:0]   bit_pos;

  pla_tseq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .prod_last_i (prod_last),
    .bit_last_i  (bit_last),
    .phase_o     (phase),
    .ring_clr_o  (ring_clr),
    .prod_step_o (prod_step),
    .bit_step_o  (bit_step),
    .done_o      (done_o)
  );

  pla_tseq_ring #(.W(N_PROD)) u_prod_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ring_clr),
    .step_i (prod_step),
    .pos_o  (prod_pos),
    .last_o (prod_last)
  );

  pla_tseq_ring #(.W(N_IN)) u_bit_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ring_clr),
    .step_i (bit_step),
    .pos_o  (bit_pos),
    .last_o (bit_last)
  );

  pla_tseq_decode #(.N_IN(N_IN), .N_PROD(N_PROD)) u_decode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .phase_i      (phase),
    .prod_pos_i   (prod_pos),
    .bit_pos_i    (bit_pos),
    .prod_last_i  (prod_last),
    .force_true_o (force_true_o),
    .force_comp_o (force_comp_o),
    .in_vec_o     (in_vec_o),
    .prod_sel_no  (prod_sel_no),
    .cmp_stb_o    (cmp_stb_o)
  );

  assign phase_o = phase;

  a_r9_start_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd2 && start_i) |=> (phase_o == 3'd2 || phase_o == 3'd3));
endmodule

// File: tb/tb_pla_tseq_gen.sv
`timescale 1ns/1ps
module tb_pla_tseq_gen;
  localparam int N = 3;
  localparam int M = 5;
  localparam int PASS_LEN = 1 + 2*M + 2*N*M;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         ft, fc, cmp, done;
  logic [N-1:0] inv;
  logic [M-1:0] psel;
  logic [2:0]   ph;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pla_tseq_gen #(.N_IN(N), .N_PROD(M)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .force_true_o(ft), .force_comp_o(fc), .in_vec_o(inv),
    .prod_sel_no(psel), .phase_o(ph), .cmp_stb_o(cmp), .done_o(done)
  );

  task automatic expect_out(input string tag, input logic [2:0] e_ph, input logic e_ft,
                            input logic e_fc, input logic [N-1:0] e_in,
                            input logic [M-1:0] e_ps, input logic e_cmp, input logic e_done);
    checks++;
    if ({ph, ft, fc, inv, psel, cmp, done} !== {e_ph, e_ft, e_fc, e_in, e_ps, e_cmp, e_done}) begin
      errors++;
      $display("FAIL %s: got ph=%0d ft=%b fc=%b in=%b ps=%b cmp=%b done=%b, exp ph=%0d ft=%b fc=%b in=%b ps=%b cmp=%b done=%b",
               tag, ph, ft, fc, inv, psel, cmp, done, e_ph, e_ft, e_fc, e_in, e_ps, e_cmp, e_done);
    end
  endtask

  function automatic logic [M-1:0] sel_zero(int j);
    logic [M-1:0] v = '1;
    v[j] = 1'b0;
    return v;
  endfunction

  function automatic logic [N-1:0] one_at(int i);
    logic [N-1:0] v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  // Called at the negedge where the quiet pattern is visible; walks the pass and the done cycle.
  task automatic walk(input bit hold_start, input bit start_on_done);
    int cycles = 0;
    start = hold_start;
    expect_out("R2 quiet", 3'd1, 1, 1, '0, '1, 1, 0);
    cycles++; @(negedge clk);
    for (int j = 0; j < M; j++) begin
      expect_out("R3 prod-hi", 3'd2, 1, 1, '1, sel_zero(j), 1, 0);
      cycles++; @(negedge clk);
    end
    for (int j = 0; j < M; j++) begin
      expect_out("R4 prod-lo", 3'd3, 1, 1, '0, sel_zero(j), 1, 0);
      cycles++; @(negedge clk);
    end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < M; j++) begin
        expect_out(hold_start ? "R5 R7 R9 true side" : "R5 R7 true side", 3'd4, 0, 1,
                   one_at(i), sel_zero(j), (j == M-1), 0);
        cycles++; @(negedge clk);
      end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < M; j++) begin
        expect_out("R6 R7 comp side", 3'd5, 1, 0, ~one_at(i), sel_zero(j), (j == M-1), 0);
        cycles++;
        if (i == N-1 && j == M-1) start = start_on_done;
        @(negedge clk);
      end
    checks++;
    if (cycles != PASS_LEN || done !== 1'b1) begin
      errors++;
      $display("FAIL R8 pass length: got %0d cycles done=%b, exp %0d done=1", cycles, done, PASS_LEN);
    end
    expect_out("R8 done cycle", 3'd0, 1, 1, '0, '1, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1 reset", 3'd0, 1, 1, '0, '1, 0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_out("R1 idle", 3'd0, 1, 1, '0, '1, 0, 0);

    // Pass 1: single start pulse.
    start = 1'b1; @(negedge clk); start = 1'b0;
    walk(0, 0);
    @(negedge clk);
    expect_out("R8 done one cycle", 3'd0, 1, 1, '0, '1, 0, 0);

    // Pass 2: start held high throughout (R9), still high in the done cycle (R10).
    start = 1'b1; @(negedge clk);
    walk(1, 1);
    @(negedge clk);
    // R10: the done-cycle start launches pass 3.
    walk(0, 0);
    @(negedge clk);
    expect_out("R10 back to idle", 3'd0, 1, 1, '0, '1, 0, 0);
    repeat (4) @(negedge clk);
    expect_out("R1 idle stays", 3'd0, 1, 1, '0, '1, 0, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule